// File: doc/BRIEF.md
# Machine-mode double-trap guard

This block owns the machine-level interrupt-enable bit (MIE) and the machine trap-disable bit (MDT), and it decides what happens to each trap request aimed at machine mode. While MDT is clear, a trap is delivered normally. The block saves the faulting pc and cause, sets MDT and clears MIE. A trap that arrives while the trap handler is still in its non-reentrant window is an unexpected trap. That window is marked by MDT being set, or by the non-maskable handler running with its enable (NMIE) cleared. Such a trap is sent to the resumable non-maskable interrupt handler, which has save registers of its own. When that path is disabled or already busy, the block freezes in a critical-error state instead.

Explicit writes to the status register apply a cross-bit interlock: MIE can never be 1 while MDT is 1. A machine-return strobe clears MDT. The core's control logic drives the trap request, the write port and the return strobe. It reads back the selected trap target one cycle after the request and redirects fetch to match.

Top module: `mdt_guard`

## Requirements
- R1: After reset, MDT is 1, MIE is 0, NMIE is 1, the critical-error output is 0, the trap target is NONE (0), and all save registers and the recorded previous privilege are 0.
- R2: A status write with data bit 42 (MDT) set leaves MDT at 1 and MIE at 0 after the edge, whatever data bit 3 (MIE) holds.
- R3: A status write with data bit 42 clear sets MDT to 0 and MIE to the value of data bit 3.
- R4: A trap request while MDT is 0 and the non-maskable path is not blocked gives target MTRAP (1) one cycle later. It loads the machine pc and cause save registers, sets MDT and clears MIE.
- R5: A trap request while MDT is 1 gives target NMI (2) when the non-maskable path is enabled and NMIE is 1. It loads the non-maskable pc and cause save registers, clears NMIE and records privilege 3 (machine). The machine save registers, MDT and MIE do not change.
- R6: A trap request while MDT is 1 with the non-maskable path disabled gives target HALT (3), raises the critical-error output, and changes no other state.
- R7: With the non-maskable path enabled and NMIE 0, any trap request is unexpected and gives HALT, even when MDT is 0.
- R8: A machine-return strobe clears MDT and leaves MIE unchanged.
- R9: Once raised, the critical-error output stays high until reset. Trap requests (target stays NONE), status writes and return strobes then have no effect.
- R10: Priority is trap request, then return strobe, then status write. A lower-priority request in the same cycle is discarded.
- R11: The interrupt-allow output equals MIE and the non-maskable-allow output equals path-enable AND NMIE. Both are forced to 0 in the critical-error state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trap_req_i | input | 1 | Trap request into machine mode |
| trap_cause_i | input | CAUSE_W | Cause code of the request |
| trap_pc_i | input | XLEN | Faulting pc |
| csr_we_i | input | 1 | Status register write strobe |
| csr_wdata_i | input | XLEN | Status register write data (MIE bit 3, MDT bit 42) |
| mret_i | input | 1 | Return-from-machine-trap strobe |
| nmi_en_i | input | 1 | Enables the resumable non-maskable redirect path |
| trap_tgt_o | output | 2 | Target for the last cycle's request: 0 NONE, 1 MTRAP, 2 NMI, 3 HALT |
| mepc_o | output | XLEN | Machine saved pc |
| mcause_o | output | CAUSE_W | Machine saved cause |
| mnepc_o | output | XLEN | Non-maskable saved pc |
| mncause_o | output | CAUSE_W | Non-maskable saved cause |
| mdt_o | output | 1 | MDT bit |
| mie_o | output | 1 | MIE bit |
| nmie_o | output | 1 | NMIE bit |
| mnpp_o | output | 2 | Privilege recorded on a non-maskable redirect |
| crit_err_o | output | 1 | Critical-error state, sticky |
| irq_allow_o | output | 1 | Ordinary interrupts may be taken |
| nmi_allow_o | output | 1 | Non-maskable interrupts may be taken |

## Verification
Every state result and the trap target come from a register, so they are due exactly one edge after the inputs that cause them. The two allow outputs also follow the current path-enable input combinationally. The bench drives inputs on the falling edge and advances its reference model at that moment. It compares every output on the next falling edge, a full cycle later, so each result is checked in the cycle it first appears. The allow outputs are compared against the path-enable value that is still being applied at that time.

// File: rtl/dtg_pkg.sv
package dtg_pkg;
  typedef enum logic [1:0] {
    TGT_NONE  = 2'd0,
    TGT_MTRAP = 2'd1,
    TGT_NMI   = 2'd2,
    TGT_HALT  = 2'd3
  } trap_tgt_e;

  localparam logic [1:0] PRIV_M = 2'b11;
endpackage

// File: rtl/dtg_decide.sv
module dtg_decide (
  input  logic trap_req_i,
  input  logic mdt_i,
  input  logic nmie_i,
  input  logic nmi_en_i,
  input  logic crit_i,
  output logic take_m_o,
  output logic take_nmi_o,
  output logic halt_o
);
  logic live, unexpected, nmi_ready;

  assign live       = trap_req_i & ~crit_i;
  assign nmi_ready  = nmi_en_i & nmie_i;
  // handler busy: either trap-disable set or NMI handler not yet re-armed
  assign unexpected = mdt_i | (nmi_en_i & ~nmie_i);

  assign take_m_o   = live & ~unexpected;
  assign take_nmi_o = live & unexpected & nmi_ready;
  assign halt_o     = live & unexpected & ~nmi_ready;
endmodule

// File: rtl/dtg_status.sv
module dtg_status (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hold_i,
  input  logic trap_enter_i,
  input  logic mret_i,
  input  logic csr_we_i,
  input  logic wr_mdt_i,
  input  logic wr_mie_i,
  output logic mdt_o,
  output logic mie_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mdt_o <= 1'b1;
      mie_o <= 1'b0;
    end else if (hold_i) begin
      mdt_o <= mdt_o;
    end else if (trap_enter_i) begin
      mdt_o <= 1'b1;
      mie_o <= 1'b0;
    end else if (mret_i) begin
      mdt_o <= 1'b0;
    end else if (csr_we_i) begin
      mdt_o <= wr_mdt_i;
      mie_o <= wr_mie_i & ~wr_mdt_i; // interlock
    end
  end
endmodule

// File: rtl/dtg_save.sv
module dtg_save #(
  parameter int unsigned PC_W    = 64,
  parameter int unsigned CAUSE_W = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cap_i,
  input  logic [PC_W-1:0]    pc_i,
  input  logic [CAUSE_W-1:0] cause_i,
  output logic [PC_W-1:0]    pc_o,
  output logic [CAUSE_W-1:0] cause_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_o    <= '0;
      cause_o <= '0;
    end else if (cap_i) begin
      pc_o    <= pc_i;
      cause_o <= cause_i;
    end
  end
endmodule

// File: rtl/mdt_guard.sv
module mdt_guard #(
  parameter int unsigned XLEN    = 64,
  parameter int unsigned CAUSE_W = 6,
  parameter int unsigned MIE_POS = 3,
  parameter int unsigned MDT_POS = 42
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               trap_req_i,
  input  logic [CAUSE_W-1:0] trap_cause_i,
  input  logic [XLEN-1:0]    trap_pc_i,
  input  logic               csr_we_i,
  input  logic [XLEN-1:0]    csr_wdata_i,
  input  logic               mret_i,
  input  logic               nmi_en_i,
  output logic [1:0]         trap_tgt_o,
  output logic [XLEN-1:0]    mepc_o,
  output logic [CAUSE_W-1:0] mcause_o,
  output logic [XLEN-1:0]    mnepc_o,
  output logic [CAUSE_W-1:0] mncause_o,
  output logic               mdt_o,
  output logic               mie_o,
  output logic               nmie_o,
  output logic [1:0]         mnpp_o,
  output logic               crit_err_o,
  output logic               irq_allow_o,
  output logic               nmi_allow_o
);
  import dtg_pkg::*;

  localparam int unsigned N_BANK = 2; // 0: machine, 1: non-maskable

  logic take_m, take_nmi, halt, hold;
  logic nmie_q, crit_q;
  logic [1:0] mnpp_q;
  trap_tgt_e tgt_q;
  logic [N_BANK-1:0]  cap;
  logic [XLEN-1:0]    epc_q   [N_BANK];
  logic [CAUSE_W-1:0] cause_q [N_BANK];
  logic unused_wdata;

  assign unused_wdata = ^csr_wdata_i;

  dtg_decide u_decide (
    .trap_req_i (trap_req_i),
    .mdt_i      (mdt_o),
    .nmie_i     (nmie_q),
    .nmi_en_i   (nmi_en_i),
    .crit_i     (crit_q),
    .take_m_o   (take_m),
    .take_nmi_o (take_nmi),
    .halt_o     (halt)
  );

  // a trap that is not a normal entry, or a frozen hart, discards updates
  assign hold = crit_q | (trap_req_i & ~take_m);

  dtg_status u_status (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .hold_i       (hold),
    .trap_enter_i (take_m),
    .mret_i       (mret_i),
    .csr_we_i     (csr_we_i),
    .wr_mdt_i     (csr_wdata_i[MDT_POS]),
    .wr_mie_i     (csr_wdata_i[MIE_POS]),
    .mdt_o        (mdt_o),
    .mie_o        (mie_o)
  );

  assign cap = {take_nmi, take_m};

  for (genvar g = 0; g < N_BANK; g++) begin : g_bank
    dtg_save #(.PC_W(XLEN), .CAUSE_W(CAUSE_W)) u_save (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .cap_i   (cap[g]),
      .pc_i    (trap_pc_i),
      .cause_i (trap_cause_i),
      .pc_o    (epc_q[g]),
      .cause_o (cause_q[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nmie_q <= 1'b1;
      mnpp_q <= 2'b00;
      crit_q <= 1'b0;
      tgt_q  <= TGT_NONE;
    end else begin
      if (halt)          tgt_q <= TGT_HALT;
      else if (take_nmi) tgt_q <= TGT_NMI;
      else if (take_m)   tgt_q <= TGT_MTRAP;
      else               tgt_q <= TGT_NONE;
      if (take_nmi) begin
        nmie_q <= 1'b0;
        mnpp_q <= PRIV_M;
      end
      if (halt) crit_q <= 1'b1;
    end
  end

  assign trap_tgt_o  = tgt_q;
  assign mepc_o      = epc_q[0];
  assign mcause_o    = cause_q[0];
  assign mnepc_o     = epc_q[1];
  assign mncause_o   = cause_q[1];
  assign nmie_o      = nmie_q;
  assign mnpp_o      = mnpp_q;
  assign crit_err_o  = crit_q;
  assign irq_allow_o = mie_o & ~crit_q;
  assign nmi_allow_o = nmi_en_i & nmie_q & ~crit_q;
endmodule

// File: rtl/dtg_guard_chk.sv
module dtg_guard_chk #(
  parameter int unsigned XLEN    = 64,
  parameter int unsigned CAUSE_W = 6,
  parameter int unsigned MIE_POS = 3,
  parameter int unsigned MDT_POS = 42
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               trap_req_i,
  input logic               csr_we_i,
  input logic [XLEN-1:0]    csr_wdata_i,
  input logic               mret_i,
  input logic               nmi_en_i,
  input logic [1:0]         trap_tgt_o,
  input logic [XLEN-1:0]    mepc_o,
  input logic [CAUSE_W-1:0] mcause_o,
  input logic               mdt_o,
  input logic               mie_o,
  input logic               nmie_o,
  input logic               crit_err_o,
  input logic               irq_allow_o,
  input logic               nmi_allow_o
);
  // R2
  mdt_set_clears_mie_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_we_i && !trap_req_i && !mret_i && !crit_err_o && csr_wdata_i[MDT_POS])
    |=> (mdt_o && !mie_o));

  // R2
  mie_never_with_mdt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mdt_o && mie_o));

  // R4
  normal_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_req_i && !crit_err_o && !mdt_o && (!nmi_en_i || nmie_o))
    |=> (trap_tgt_o == 2'd1 && mdt_o && !mie_o));

  // R5
  nmi_redirect_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_req_i && !crit_err_o && mdt_o && nmi_en_i && nmie_o)
    |=> (trap_tgt_o == 2'd2 && !nmie_o && $stable(mepc_o) && $stable(mcause_o)));

  // R6
  halt_no_nmi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_req_i && !crit_err_o && mdt_o && !nmi_en_i)
    |=> (trap_tgt_o == 2'd3 && crit_err_o && $stable(mepc_o) && $stable(mdt_o)));

  // R8
  mret_clears_mdt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mret_i && !trap_req_i && !crit_err_o) |=> (!mdt_o && $stable(mie_o)));

  // R9
  crit_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    crit_err_o |=> (crit_err_o && trap_tgt_o == 2'd0 && $stable(mdt_o) && $stable(mie_o)));

  // R11
  crit_masks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    crit_err_o |-> (!irq_allow_o && !nmi_allow_o));
endmodule

bind mdt_guard dtg_guard_chk #(
  .XLEN(XLEN), .CAUSE_W(CAUSE_W), .MIE_POS(MIE_POS), .MDT_POS(MDT_POS)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .trap_req_i  (trap_req_i),
  .csr_we_i    (csr_we_i),
  .csr_wdata_i (csr_wdata_i),
  .mret_i      (mret_i),
  .nmi_en_i    (nmi_en_i),
  .trap_tgt_o  (trap_tgt_o),
  .mepc_o      (mepc_o),
  .mcause_o    (mcause_o),
  .mdt_o       (mdt_o),
  .mie_o       (mie_o),
  .nmie_o      (nmie_o),
  .crit_err_o  (crit_err_o),
  .irq_allow_o (irq_allow_o),
  .nmi_allow_o (nmi_allow_o)
);

// File: tb/tb_mdt_guard.sv
module tb_mdt_guard;
  localparam int XLEN = 64;
  localparam int CW   = 6;
  localparam logic [63:0] B_MIE = 64'h8;
  localparam logic [63:0] B_MDT = 64'h1 << 42;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tr = 1'b0, we = 1'b0, mr = 1'b0, ne = 1'b0;
  logic [CW-1:0] cause = '0;
  logic [XLEN-1:0] pc = '0, wd = '0;

  logic [1:0] tgt, mnpp;
  logic [XLEN-1:0] mepc, mnepc;
  logic [CW-1:0] mcause, mncause;
  logic mdt, mie, nmie, crit, irq_ok, nmi_ok;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  string last_tag = "R1";

  // reference state
  int e_tgt, e_mnpp;
  bit e_mdt, e_mie, e_nmie, e_crit, e_ne;
  logic [63:0] e_mepc, e_mnepc;
  int e_mcause, e_mncause;

  always #4 clk = ~clk;

  mdt_guard dut (
    .clk_i(clk), .rst_ni(rst_n), .trap_req_i(tr), .trap_cause_i(cause),
    .trap_pc_i(pc), .csr_we_i(we), .csr_wdata_i(wd), .mret_i(mr),
    .nmi_en_i(ne), .trap_tgt_o(tgt), .mepc_o(mepc), .mcause_o(mcause),
    .mnepc_o(mnepc), .mncause_o(mncause), .mdt_o(mdt), .mie_o(mie),
    .nmie_o(nmie), .mnpp_o(mnpp), .crit_err_o(crit),
    .irq_allow_o(irq_ok), .nmi_allow_o(nmi_ok)
  );

  task automatic chk(input string nm, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", last_tag, nm, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("tgt", 64'(tgt), 64'(e_tgt));
    chk("mepc", mepc, e_mepc);
    chk("mcause", 64'(mcause), 64'(e_mcause));
    chk("mnepc", mnepc, e_mnepc);
    chk("mncause", 64'(mncause), 64'(e_mncause));
    chk("mdt", 64'(mdt), 64'(e_mdt));
    chk("mie", 64'(mie), 64'(e_mie));
    chk("nmie", 64'(nmie), 64'(e_nmie));
    chk("mnpp", 64'(mnpp), 64'(e_mnpp));
    chk("crit", 64'(crit), 64'(e_crit));
    // R11 allow outputs
    chk("irq_allow", 64'(irq_ok), 64'(e_mie && !e_crit));
    chk("nmi_allow", 64'(nmi_ok), 64'(e_ne && e_nmie && !e_crit));
  endtask

  task automatic model_reset();
    e_tgt = 0; e_mnpp = 0; e_mdt = 1; e_mie = 0; e_nmie = 1; e_crit = 0;
    e_mepc = 0; e_mnepc = 0; e_mcause = 0; e_mncause = 0;
  endtask

  task automatic do_reset(input bit nmi_path);
    @(negedge clk);
    rst_n = 1'b0; tr = 0; we = 0; mr = 0; ne = nmi_path; e_ne = nmi_path;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    last_tag = "R1";
  endtask

  // compare last cycle's result, then apply new inputs and advance the model
  task automatic cyc(input string tag, input bit t, input int c, input logic [63:0] p,
                     input bit w, input logic [63:0] d, input bit r, input bit n);
    bit unexp;
    @(negedge clk);
    compare_all();
    tr = t; cause = CW'(c); pc = p; we = w; wd = d; mr = r; ne = n;
    e_ne = n;
    last_tag = tag;
    e_tgt = 0;
    if (!e_crit) begin
      if (t) begin
        unexp = e_mdt || (n && !e_nmie);
        if (!unexp) begin
          e_mepc = p; e_mcause = c; e_mdt = 1; e_mie = 0; e_tgt = 1;
        end else if (n && e_nmie) begin
          e_mnepc = p; e_mncause = c; e_nmie = 0; e_mnpp = 3; e_tgt = 2;
        end else begin
          e_crit = 1; e_tgt = 3;
        end
      end else if (r) begin
        e_mdt = 0;
      end else if (w) begin
        e_mdt = d[42];
        e_mie = d[3] && !d[42];
      end
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    do_reset(1'b1);
    cyc("R1", 0, 0, 0, 0, 0, 0, 1);
    cyc("R3", 0, 0, 0, 1, B_MIE, 0, 1);            // clear MDT, set MIE
    cyc("R2", 0, 0, 0, 1, B_MDT | B_MIE, 0, 1);    // MIE forced off
    cyc("R3", 0, 0, 0, 1, B_MIE, 0, 1);
    cyc("R4", 1, 5, 64'hA000, 0, 0, 0, 1);         // normal entry
    cyc("R4", 0, 0, 0, 0, 0, 0, 1);
    cyc("R8", 0, 0, 0, 0, 0, 1, 1);                // clear MDT
    cyc("R3", 0, 0, 0, 1, B_MIE, 0, 1);
    cyc("R8", 0, 0, 0, 0, 0, 1, 1);                // MIE stays 1
    cyc("R10", 0, 0, 0, 1, B_MDT, 1, 1);           // mret wins over write
    cyc("R11", 0, 0, 0, 0, 0, 0, 0);               // path off drops nmi_allow
    cyc("R10", 1, 7, 64'hB004, 1, B_MIE, 0, 1);    // trap wins over write
    cyc("R5", 1, 2, 64'hC008, 1, B_MIE, 0, 1);     // MDT set -> redirect
    cyc("R5", 0, 0, 0, 0, 0, 0, 1);
    cyc("R8", 0, 0, 0, 0, 0, 1, 1);
    cyc("R7", 1, 9, 64'hD00C, 0, 0, 0, 1);         // NMIE 0 -> halt
    cyc("R9", 1, 3, 64'hE010, 0, 0, 0, 1);
    cyc("R9", 0, 0, 0, 1, B_MIE, 0, 1);
    cyc("R9", 0, 0, 0, 0, 0, 1, 1);
    cyc("R9", 0, 0, 0, 0, 0, 0, 1);
    // second run: no NMI path
    do_reset(1'b0);
    cyc("R1", 0, 0, 0, 0, 0, 0, 0);
    cyc("R6", 1, 16, 64'hF014, 0, 0, 0, 0);        // MDT is 1 out of reset
    cyc("R9", 0, 0, 0, 1, B_MIE, 0, 0);
    cyc("R9", 0, 0, 0, 0, 0, 0, 0);
    // third run: normal entry with path disabled, then unexpected trap
    do_reset(1'b0);
    cyc("R3", 0, 0, 0, 1, 64'h0, 0, 0);
    cyc("R4", 1, 11, 64'h1234, 0, 0, 0, 0);
    cyc("R6", 1, 12, 64'h5678, 0, 0, 0, 0);
    cyc("R9", 0, 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    compare_all();
    finish_run();
  end
endmodule